// File: doc/BRIEF.md
# Effective Address Generator

This block works out where an 8-bit processor's operand lives. When an instruction has been fetched, the sequencer pulses `start` and supplies an addressing-mode code, the program counter (already pointing at the first operand byte), the two index registers and the outcome of the branch condition. The block then reads the operand bytes and any pointer bytes it needs through a single read port with a 16-bit address and 8-bit data. When it has finished, it presents the effective address, the advanced program counter, the branch destination and the number of extra cycles a taken branch costs.

The old wrap behaviour is kept on purpose. Zero-page indexing stays inside page zero. Zero-page pointers fetch their second byte from the same page. The indirect jump pointer never carries into its high byte. The memory port is registered: read data appears on `memData` in the cycle after the cycle in which `memRd` is asserted. Each read therefore takes one issue cycle and one capture cycle.

Top module: `eaGen`

## Requirements
- R1: A `start` seen while the block is idle latches `mode`, `pcIn`, `xIdx`, `yIdx` and `branchTaken`. `done` is then high for exactly one cycle, 1+2n clock edges after the start edge, where n is the number of memory reads the mode needs.
- R2: Mode codes are 0 implied, 1 accumulator, 2 immediate, 3 zero page, 4 zero page+X, 5 zero page+Y, 6 relative, 7 absolute, 8 absolute+X, 9 absolute+Y, 10 indirect, 11 (zero page+X) indirect, and 12 (zero page) indirect+Y. Reads per operation are 0 for codes 0, 1, 2 and 13–15; 1 for 3–6; 2 for 7–9; 3 for 11 and 12; and 4 for 10. `memRd` is never high in two consecutive cycles.
- R3: `nextPc` is `pcIn` plus 0 for codes 0, 1 and 13–15, plus 2 for codes 7–10, and plus 1 for every other code, modulo 65536.
- R4: For zero page, `effAddr` is the operand byte. For zero page+X/Y it is (operand + index) mod 256. Both have a high byte of 0.
- R5: For absolute, the address is the little-endian word at `pcIn` (low byte) and `pcIn+1`. Absolute+X/Y adds the index with full 16-bit carry.
- R6: For indirect, pointer P is the absolute operand. `effAddr` has its low byte from P and its high byte from {P[15:8], P[7:0]+1 mod 256}, with no carry into the high pointer byte.
- R7: For (zero page+X) indirect, Z = (operand + X) mod 256. `effAddr` has its low byte from address Z and its high byte from address (Z+1) mod 256.
- R8: For (zero page) indirect+Y, the word read from page zero at the operand and at (operand+1) mod 256 is added to Y with full 16-bit carry.
- R9: For relative, `branchTarget` and `effAddr` are `nextPc` plus the sign-extended operand byte, mod 65536. For all other modes, `branchTarget` equals `nextPc`.
- R10: `extraCycles` is 0 unless the mode is relative and the branch is taken. A taken branch gives 1, or 2 when the low byte of `nextPc` plus the sign-extended offset (16-bit) carries out of the page.
- R11: `effAddr` is 0 for implied, accumulator and codes 13–15, and equals `pcIn` for immediate.
- R12: A `start` that arrives while an operation is in progress is ignored. The results stay unchanged from `done` until the next operation is accepted.
- R13: After reset, `done`, `memRd`, `effAddr`, `nextPc`, `branchTarget` and `extraCycles` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin an operation |
| mode | input | 4 | Addressing-mode code |
| pcIn | input | 16 | Address of the first operand byte |
| xIdx | input | 8 | X index register |
| yIdx | input | 8 | Y index register |
| branchTaken | input | 1 | Branch condition is true |
| memAddr | output | 16 | Read address |
| memRd | output | 1 | Read strobe |
| memData | input | 8 | Read data, valid the cycle after `memRd` |
| done | output | 1 | Results valid pulse |
| busy | output | 1 | Operation in progress |
| effAddr | output | 16 | Effective address |
| nextPc | output | 16 | Program counter past the operand |
| branchTarget | output | 16 | Relative branch destination |
| extraCycles | output | 2 | Taken-branch cycle penalty |

## Verification
Every result is due 1+2n clock edges after the start edge, where n comes from the mode's read count. The bench drives inputs on the falling edge and counts falling edges until `done` appears. It compares that count with 1+2n, and it samples all results on that same falling edge. Read strobes are counted over the same window. After `done`, the bench waits a few more falling edges and checks again that the results have held.

// File: rtl/eaGenPkg.sv
package eaGenPkg;

  localparam logic [3:0] AM_IMP = 4'd0;
  localparam logic [3:0] AM_ACC = 4'd1;
  localparam logic [3:0] AM_IMM = 4'd2;
  localparam logic [3:0] AM_ZPG = 4'd3;
  localparam logic [3:0] AM_ZPX = 4'd4;
  localparam logic [3:0] AM_ZPY = 4'd5;
  localparam logic [3:0] AM_REL = 4'd6;
  localparam logic [3:0] AM_ABS = 4'd7;
  localparam logic [3:0] AM_ABX = 4'd8;
  localparam logic [3:0] AM_ABY = 4'd9;
  localparam logic [3:0] AM_IND = 4'd10;
  localparam logic [3:0] AM_IDX = 4'd11;
  localparam logic [3:0] AM_IDY = 4'd12;

  typedef enum logic [1:0] {SL_OPLO, SL_OPHI, SL_PTLO, SL_PTHI} slot_e;

  typedef struct packed {
    logic  load;
    logic  rd;
    logic  capture;
    slot_e slot;
  } strobe_t;

  // operand bytes that must be read from memory
  function automatic logic [1:0] operandReads(input logic [3:0] m);
    case (m)
      AM_ZPG, AM_ZPX, AM_ZPY, AM_REL, AM_IDX, AM_IDY: operandReads = 2'd1;
      AM_ABS, AM_ABX, AM_ABY, AM_IND:                 operandReads = 2'd2;
      default:                                        operandReads = 2'd0;
    endcase
  endfunction

  function automatic logic usesPointer(input logic [3:0] m);
    usesPointer = (m == AM_IND) || (m == AM_IDX) || (m == AM_IDY);
  endfunction

  // program counter advance
  function automatic logic [1:0] pcStep(input logic [3:0] m);
    case (m)
      AM_IMM, AM_ZPG, AM_ZPX, AM_ZPY, AM_REL, AM_IDX, AM_IDY: pcStep = 2'd1;
      AM_ABS, AM_ABX, AM_ABY, AM_IND:                         pcStep = 2'd2;
      default:                                                pcStep = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/eaGenCtrl.sv
module eaGenCtrl
  import eaGenPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] mode,
  output strobe_t    ctl,
  output logic       done,
  output logic       busy
);

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WT, ST_FIN} state_e;

  state_e     st;
  slot_e      slot;
  logic       hasOpHi;
  logic       hasPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      slot    <= SL_OPLO;
      hasOpHi <= 1'b0;
      hasPtr  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          hasOpHi <= (operandReads(mode) == 2'd2);
          hasPtr  <= usesPointer(mode);
          slot    <= SL_OPLO;
          st      <= (operandReads(mode) != 2'd0) ? ST_RD : ST_FIN;
        end
        ST_RD: st <= ST_WT;
        ST_WT: begin
          case (slot)
            SL_OPLO: begin
              if (hasOpHi) begin slot <= SL_OPHI; st <= ST_RD; end
              else if (hasPtr) begin slot <= SL_PTLO; st <= ST_RD; end
              else st <= ST_FIN;
            end
            SL_OPHI: begin
              if (hasPtr) begin slot <= SL_PTLO; st <= ST_RD; end
              else st <= ST_FIN;
            end
            SL_PTLO: begin slot <= SL_PTHI; st <= ST_RD; end
            default: st <= ST_FIN;
          endcase
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load    = (st == ST_IDLE) && start;
    ctl.rd      = (st == ST_RD);
    ctl.capture = (st == ST_WT);
    ctl.slot    = slot;
    done        = (st == ST_FIN);
    busy        = (st != ST_IDLE);
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);                                   // R1
  AST_READ_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rd |=> !ctl.rd);                               // R2
  AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ctl.load);                               // R12

endmodule

// File: rtl/eaGenPath.sv
module eaGenPath
  import eaGenPkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       ctl,
  input  logic [3:0]    mode,
  input  logic [AW-1:0] pcIn,
  input  logic [DW-1:0] xIdx,
  input  logic [DW-1:0] yIdx,
  input  logic          branchTaken,
  input  logic [DW-1:0] memData,
  output logic [AW-1:0] memAddr,
  output logic          memRd,
  output logic [AW-1:0] effAddr,
  output logic [AW-1:0] nextPc,
  output logic [AW-1:0] branchTarget,
  output logic [1:0]    extraCycles
);

  logic [3:0]    modeQ;
  logic [AW-1:0] pcQ;
  logic [DW-1:0] xQ, yQ;
  logic          takenQ;
  logic [DW-1:0] opLo, opHi, ptLo, ptHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= AM_IMP;
      pcQ    <= '0;
      xQ     <= '0;
      yQ     <= '0;
      takenQ <= 1'b0;
      opLo   <= '0;
      opHi   <= '0;
      ptLo   <= '0;
      ptHi   <= '0;
    end else if (ctl.load) begin
      modeQ  <= mode;
      pcQ    <= pcIn;
      xQ     <= xIdx;
      yQ     <= yIdx;
      takenQ <= branchTaken;
      opLo   <= '0;
      opHi   <= '0;
      ptLo   <= '0;
      ptHi   <= '0;
    end else if (ctl.capture) begin
      case (ctl.slot)
        SL_OPLO: opLo <= memData;
        SL_OPHI: opHi <= memData;
        SL_PTLO: ptLo <= memData;
        default: ptHi <= memData;
      endcase
    end
  end

  logic [DW-1:0] zpX, zpY;
  logic [AW-1:0] operand, pointer, ptrBase, ptrNext;
  logic [AW-1:0] nextPcW, relOff, relTgt;
  logic          isRel;

  always_comb begin
    zpX     = opLo + xQ;
    zpY     = opLo + yQ;
    operand = {opHi, opLo};
    pointer = {ptHi, ptLo};
    case (modeQ)
      AM_IND:  ptrBase = operand;
      AM_IDX:  ptrBase = {{DW{1'b0}}, zpX};
      default: ptrBase = {{DW{1'b0}}, opLo};
    endcase
    // second pointer byte stays in the pointer's page
    ptrNext = {ptrBase[AW-1:DW], ptrBase[DW-1:0] + DW'(1)};
    nextPcW = pcQ + AW'(pcStep(modeQ));
    relOff  = {{DW{opLo[DW-1]}}, opLo};
    relTgt  = nextPcW + relOff;
    isRel   = (modeQ == AM_REL);
  end

  always_comb begin
    case (ctl.slot)
      SL_OPLO: memAddr = pcQ;
      SL_OPHI: memAddr = pcQ + AW'(1);
      SL_PTLO: memAddr = ptrBase;
      default: memAddr = ptrNext;
    endcase
    memRd = ctl.rd;
  end

  always_comb begin
    case (modeQ)
      AM_IMM:         effAddr = pcQ;
      AM_ZPG:         effAddr = {{DW{1'b0}}, opLo};
      AM_ZPX:         effAddr = {{DW{1'b0}}, zpX};
      AM_ZPY:         effAddr = {{DW{1'b0}}, zpY};
      AM_REL:         effAddr = relTgt;
      AM_ABS:         effAddr = operand;
      AM_ABX:         effAddr = operand + {{DW{1'b0}}, xQ};
      AM_ABY:         effAddr = operand + {{DW{1'b0}}, yQ};
      AM_IND, AM_IDX: effAddr = pointer;
      AM_IDY:         effAddr = pointer + {{DW{1'b0}}, yQ};
      default:        effAddr = '0;
    endcase
    nextPc       = nextPcW;
    branchTarget = isRel ? relTgt : nextPcW;
    if (isRel && takenQ)
      extraCycles = (relTgt[AW-1:DW] != nextPcW[AW-1:DW]) ? 2'd2 : 2'd1;
    else
      extraCycles = 2'd0;
  end

  AST_PTR_SAME_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && ctl.slot == SL_PTHI) |->
      (memAddr[AW-1:DW] == $past(memAddr[AW-1:DW], 2)) &&
      (memAddr[DW-1:0] == $past(memAddr[DW-1:0], 2) + DW'(1)));   // R6
  AST_OPHI_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && ctl.slot == SL_OPHI) |-> memAddr == $past(memAddr, 2) + AW'(1)); // R5
  AST_ZP_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == AM_ZPX || modeQ == AM_ZPY) |-> effAddr[AW-1:DW] == '0); // R4
  AST_PENALTY_CROSS: assert property (@(posedge clk) disable iff (!rstN)
    (extraCycles == 2'd2) |-> (branchTarget[AW-1:DW] != nextPc[AW-1:DW])); // R10
  AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.capture) |=> $stable(effAddr) && $stable(nextPc)); // R12

endmodule

// File: rtl/eaGen.sv
module eaGen
  import eaGenPkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [AW-1:0] pcIn,
  input  logic [DW-1:0] xIdx,
  input  logic [DW-1:0] yIdx,
  input  logic          branchTaken,
  output logic [AW-1:0] memAddr,
  output logic          memRd,
  input  logic [DW-1:0] memData,
  output logic          done,
  output logic          busy,
  output logic [AW-1:0] effAddr,
  output logic [AW-1:0] nextPc,
  output logic [AW-1:0] branchTarget,
  output logic [1:0]    extraCycles
);

  strobe_t ctl;

  eaGenCtrl uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .mode  (mode),
    .ctl   (ctl),
    .done  (done),
    .busy  (busy)
  );

  eaGenPath #(.DW(DW)) uPath (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .mode         (mode),
    .pcIn         (pcIn),
    .xIdx         (xIdx),
    .yIdx         (yIdx),
    .branchTaken  (branchTaken),
    .memData      (memData),
    .memAddr      (memAddr),
    .memRd        (memRd),
    .effAddr      (effAddr),
    .nextPc       (nextPc),
    .branchTarget (branchTarget),
    .extraCycles  (extraCycles)
  );

endmodule

// File: tb/eaGen_test.sv
module eaGen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] pcIn = '0;
  logic [7:0]  xIdx = '0, yIdx = '0;
  logic        branchTaken = 1'b0;
  logic [15:0] memAddr;
  logic        memRd;
  logic [7:0]  memData = '0;
  logic        done, busy;
  logic [15:0] effAddr, nextPc, branchTarget;
  logic [1:0]  extraCycles;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  eaGen uut (.*);

  // memory contents: bijective within each page
  function automatic logic [7:0] mb(input logic [15:0] a);
    mb = a[7:0] ^ {a[10:8], a[15:11]} ^ 8'h3C;
  endfunction

  always @(posedge clk) if (memRd) memData <= mb(memAddr);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runOp(input int md, input int pc, input int x, input int y,
                       input bit tk, input bit inject);
    int lat, rdCnt, nReads, step, npc, op, op16, p, lo, hi, ea, off, tgt, ex;
    int z, held;
    @(negedge clk);
    mode = md[3:0]; pcIn = pc[15:0]; xIdx = x[7:0]; yIdx = y[7:0];
    branchTaken = tk; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1; rdCnt = 0;
    while (!done && lat < 40) begin
      if (memRd) rdCnt++;
      if (inject && lat == 2) begin start = 1'b1; mode = 4'd0; pcIn = ~pcIn; end
      else start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    case (md)
      3,4,5,6: nReads = 1;
      7,8,9:   nReads = 2;
      10:      nReads = 4;
      11,12:   nReads = 3;
      default: nReads = 0;
    endcase
    case (md)
      0,1,13,14,15: step = 0;
      7,8,9,10:     step = 2;
      default:      step = 1;
    endcase
    npc  = (pc + step) % 65536;
    op   = mb(pc[15:0]);
    op16 = op + 256 * mb(16'((pc + 1) % 65536));
    off  = (op >= 128) ? op - 256 : op;
    tgt  = (npc + off + 65536) % 65536;
    ea = 0;
    case (md)
      2:  ea = pc;
      3:  ea = op;
      4:  ea = (op + x) % 256;
      5:  ea = (op + y) % 256;
      6:  ea = tgt;
      7:  ea = op16;
      8:  ea = (op16 + x) % 65536;
      9:  ea = (op16 + y) % 65536;
      10: begin
            p = op16;
            lo = mb(p[15:0]);
            hi = mb(16'((p & 32'hFF00) | ((p + 1) & 32'hFF)));
            ea = lo + 256 * hi;
          end
      11: begin
            z = (op + x) % 256;
            ea = mb(z[15:0]) + 256 * mb(16'((z + 1) % 256));
          end
      12: ea = (mb(op[15:0]) + 256 * mb(16'((op + 1) % 256)) + y) % 65536;
      default: ea = 0;
    endcase
    if (md == 6 && tk)
      ex = ((((npc & 255) + (off & 32'hFFFF)) & 32'hFF00) != 0) ? 2 : 1;
    else ex = 0;
    chk("R1 latency", lat, 1 + 2 * nReads);
    chk("R2 reads", rdCnt, nReads);
    chk("R3 nextPc", nextPc, npc);
    case (md)
      3,4,5:  chk("R4 zero page addr", effAddr, ea);
      7,8,9:  chk("R5 absolute addr", effAddr, ea);
      10:     chk("R6 indirect addr", effAddr, ea);
      11:     chk("R7 x-indirect addr", effAddr, ea);
      12:     chk("R8 indirect-y addr", effAddr, ea);
      6:      chk("R9 relative addr", effAddr, ea);
      default: chk("R11 plain addr", effAddr, ea);
    endcase
    chk("R9 branchTarget", branchTarget, (md == 6) ? tgt : npc);
    chk("R10 extraCycles", extraCycles, ex);
    if (inject) begin
      held = effAddr;
      repeat (3) @(negedge clk);
      chk("R12 held effAddr", effAddr, held);
      chk("R12 held nextPc", nextPc, npc);
      chk("R12 no restart", busy, 0);
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R13 done", done, 0);
    chk("R13 memRd", memRd, 0);
    chk("R13 effAddr", effAddr, 0);
    chk("R13 nextPc", nextPc, 0);
    chk("R13 branchTarget", branchTarget, 0);
    chk("R13 extraCycles", extraCycles, 0);
    rstN = 1'b1;
    for (int md = 0; md < 16; md++) begin
      for (int k = 0; k < 256; k++) begin
        int hi;
        hi = md[0] ? 255 - md : 64 + md;
        runOp(md, hi * 256 + k, (k * 37 + md) % 256, ((k * 11) ^ 128) % 256,
              k[1], 1'b0);
      end
    end
    // R12: start pulses during busy operations are ignored
    runOp(7, 16'h12FF, 8'h05, 8'h09, 1'b0, 1'b1);
    runOp(10, 16'h3480, 8'h00, 8'h00, 1'b0, 1'b1);
    runOp(6, 16'h20F0, 8'h00, 8'h00, 1'b1, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule